// File: doc/BRIEF.md
# Low-Voltage Detector Control Register

This block holds the software-visible control and status for a supply-voltage detector. A small 8-bit bus port selects one of two registers: a status/control register, and a level register whose value drives the analog threshold selection. The comparator's "supply is low" output arrives asynchronously. It is synchronized and turned into a detection flag, a single-cycle interrupt pulse and a level reset request.

The level register is write-protected. It can only be changed after an unlock bit has been set, and that bit can only be set while the operating mode input selects the combined interrupt-and-reset mode. In that mode the block raises a mask flag to suppress its own requests during unsafe windows:
- while the level register is unlocked;
- while a settling counter runs after an interrupt event;
- while a settling counter runs after a change of the threshold level.

A reset caused by the detector itself leaves the unlock bit untouched. Every other reset clears it.

Top module: `lvd_ctrl`

## Requirements
- R1: With `bus_sel`=0, `bus_rdata` reads bit 7 = unlock, bits 6..2 = 0, bit 1 = mask flag, bit 0 = detection flag. With `bus_sel`=1 it reads the level value in bits LVL_W-1..0 and zeros above.
- R2: Bus writes to bits 1 and 0 of the status register have no effect on what those bits read.
- R3: A reset with `rst_from_lvd`=0 clears the status register to 0x00. A reset with `rst_from_lvd`=1 keeps the unlock bit. Both kinds of reset return the level register to LVL_INIT (default 0).
- R4: A level write (`bus_sel`=1) is ignored while unlock is 0 and is stored while unlock is 1.
- R5: Writing the unlock bit takes effect only when `mode` = 2'b10 (interrupt-and-reset). In any other mode, status writes leave it unchanged.
- R6: With `mode` = 2'b10 and unlock = 1, the mask flag reads 1 and `rst_req` is 0.
- R7: An accepted level write that changes the value, or an unmasked interrupt event, loads a settling counter with SETTLE_CYCLES (default 300). With `mode` = 2'b10 the mask reads 1 for exactly SETTLE_CYCLES clock edges after the loading edge. A level write of an unchanged value does not load it.
- R8: The detection flag is `det_en` AND the comparator input after a two-flop synchronizer. It reads 1 after the second rising edge following `cmp_low` going high, and reads 0 whenever `det_en` is 0.
- R9: `irq_pulse` is high for exactly one cycle, one edge after the detection flag rises, and only if the mask was 0 at that rise.
- R10: `rst_req` is 1 exactly when `mode` = 2'b10, the detection flag is 1 and the mask is 0. It is never 1 in other modes.
- R11: In any mode other than 2'b10, the mask flag reads 0, even while the settling counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_from_lvd | input | 1 | High when the current reset was caused by the detector |
| mode | input | 2 | Operating mode; 2'b10 = interrupt-and-reset |
| det_en | input | 1 | Detector enabled |
| cmp_low | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| bus_sel | input | 1 | Register select: 0 status, 1 level |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| level_sel | output | LVL_W | Current threshold level |
| irq_pulse | output | 1 | One-cycle interrupt request |
| rst_req | output | 1 | Reset request (interrupt-and-reset mode only) |

## Verification
The assertions assume that `mode` and `det_en` are quasi-static. They change only between scenarios, never in the same cycle as a bus write or a comparator transition. They also assume `rst_from_lvd` is meaningful only while `rst_n` is low. The bench drives every input on the falling clock edge, and changes the mode only while the settling counter is idle or when the mask does not matter. It holds `cmp_low` steady for several cycles at a time, so the synchronizer never sees a glitch narrower than a clock period.

// File: rtl/lvd_ctrl.sv
module lvd_ctrl #(
  parameter int SETTLE_CYCLES = 300,
  parameter int LVL_W = 4,
  parameter logic [LVL_W-1:0] LVL_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_from_lvd,
  input  logic [1:0]       mode,
  input  logic             det_en,
  input  logic             cmp_low,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [LVL_W-1:0] level_sel,
  output logic             irq_pulse,
  output logic             rst_req
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [1:0] MODE_IR = 2'b10;

  logic          unlock;
  logic [LVL_W-1:0] level;
  logic [CW-1:0] settle;
  logic          sync1, sync2, flag_q, irq_q;
  logic          ir_mode, flag, mask, irq_evt, wr_stat, wr_lvl, lvl_chg;
  logic [7:0]    lvl_rd;
  logic          unused_wbits;

  assign ir_mode = (mode == MODE_IR);
  assign flag    = det_en & sync2;
  assign mask    = ir_mode & (unlock | (settle != '0));
  assign irq_evt = flag & ~flag_q & ~mask;
  assign wr_stat = bus_wr & ~bus_sel;
  assign wr_lvl  = bus_wr & bus_sel & unlock;
  assign lvl_chg = wr_lvl && (bus_wdata[LVL_W-1:0] != level);
  assign unused_wbits = ^bus_wdata;

  always_comb begin
    lvl_rd = '0;
    lvl_rd[LVL_W-1:0] = level;
  end

  assign bus_rdata = bus_sel ? lvl_rd : {unlock, 5'b0, mask, flag};
  assign level_sel = level;
  assign irq_pulse = irq_q;
  assign rst_req   = ir_mode & flag & ~mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= 1'b0;
      sync2  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      settle <= '0;
      level  <= LVL_INIT;
      if (!rst_from_lvd) unlock <= 1'b0;
    end else begin
      sync1  <= cmp_low;
      sync2  <= sync1;
      flag_q <= flag;
      irq_q  <= irq_evt;
      if (wr_stat && ir_mode) unlock <= bus_wdata[7];
      if (wr_lvl) level <= bus_wdata[LVL_W-1:0];
      if (irq_evt || lvl_chg) settle <= CW'(SETTLE_CYCLES);
      else if (settle != '0)  settle <= settle - 1'b1;
    end
  end

  assert_status_pad_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata[6:2] == 5'b0);

  assert_level_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |=> $stable(level_sel));

  assert_unlock_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock) |-> $past(mode) == MODE_IR);

  assert_unlock_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_mode && unlock) |-> !rst_req);

  assert_irq_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(mask));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
endmodule

// File: tb/lvd_ctrl_bench.sv
module lvd_ctrl_bench;
  localparam int SETTLE = 300;
  logic clk = 1'b0;
  logic rst_n = 1'b0, rst_from_lvd = 1'b0;
  logic [1:0] mode = 2'b10;
  logic det_en = 1'b1, cmp_low = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [3:0] level_sel;
  logic irq_pulse, rst_req;
  int checks = 0, fails = 0, cyc = 0, wr_cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lvd_ctrl #(.SETTLE_CYCLES(SETTLE), .LVL_W(4)) u_lvd_ctrl (
    .clk(clk), .rst_n(rst_n), .rst_from_lvd(rst_from_lvd), .mode(mode),
    .det_en(det_en), .cmp_low(cmp_low), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .level_sel(level_sel),
    .irq_pulse(irq_pulse), .rst_req(rst_req));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 wr_cyc = cyc;
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    bus_sel = s;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    step(3); rst_n = 1'b1; step(1);
    rd(0, v); chk("R3 status after reset", v, 8'h00);
    rd(1, v); chk("R3 level after reset", v, 8'h00);
    chk("R10 rst_req idle", rst_req, 0);
  endtask

  task automatic t_mode_lock();
    logic [7:0] v;
    mode = 2'b01;
    wr(0, 8'h80); rd(0, v); chk("R5 unlock ignored outside mode", v, 8'h00);
    wr(1, 8'h05); rd(1, v); chk("R4 level write blocked", v, 8'h00);
  endtask

  task automatic t_unlock_settle();
    logic [7:0] v;
    int e, n;
    mode = 2'b10;
    wr(0, 8'h80); rd(0, v); chk("R6 R1 unlocked status", v, 8'h82);
    wr(0, 8'hFF); rd(0, v); chk("R2 read-only bits", v, 8'h82);
    wr(1, 8'h07); e = wr_cyc;
    rd(1, v); chk("R4 level write accepted", v, 8'h07);
    chk("R4 level output", level_sel, 7);
    wr(0, 8'h00); rd(0, v); chk("R7 mask during settling", v, 8'h02);
    n = 0;
    while (bus_rdata[1] && n < 1000) begin step(1); n++; end
    chk("R7 settle length", cyc - e, SETTLE);
    wr(0, 8'h80); wr(1, 8'h07); wr(0, 8'h00);
    rd(0, v); chk("R7 same value no settle", v, 8'h00);
  endtask

  task automatic t_flag_irq();
    logic [7:0] v;
    mode = 2'b01;
    @(negedge clk); cmp_low = 1'b1;
    step(1); rd(0, v); chk("R8 flag after one edge", v, 8'h00);
    step(1); rd(0, v); chk("R8 flag after two edges", v, 8'h01);
    chk("R9 no irq yet", irq_pulse, 0);
    chk("R10 no rst_req outside mode", rst_req, 0);
    step(1); chk("R9 irq pulse", irq_pulse, 1);
    rd(0, v); chk("R11 no mask outside mode", v, 8'h01);
    step(1); chk("R9 irq one cycle", irq_pulse, 0);
    det_en = 1'b0; #1;
    rd(0, v); chk("R8 flag off when disabled", v, 8'h00);
    cmp_low = 1'b0; step(3); det_en = 1'b1;
    step(SETTLE + 10);
  endtask

  task automatic t_ir_mode();
    logic [7:0] v;
    int e;
    mode = 2'b10;
    @(negedge clk); cmp_low = 1'b1;
    step(2); chk("R10 rst_req before mask", rst_req, 1);
    step(1); chk("R9 irq in ir mode", irq_pulse, 1);
    chk("R10 rst_req masked", rst_req, 0);
    e = cyc;
    rd(0, v); chk("R7 mask after irq", v, 8'h03);
    step(SETTLE - 1); rd(0, v); chk("R7 mask last cycle", v, 8'h03);
    step(1); chk("R7 released edges", cyc - e, SETTLE);
    chk("R10 rst_req after release", rst_req, 1);
    cmp_low = 1'b0; step(3);
    chk("R10 rst_req cleared", rst_req, 0);
  endtask

  task automatic t_masked();
    logic [7:0] v;
    int seen = 0;
    wr(0, 8'h80);
    cmp_low = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1);
      if (irq_pulse || rst_req) seen++;
    end
    chk("R6 R9 requests masked while unlocked", seen, 0);
    rd(0, v); chk("R1 full status", v, 8'h83);
    wr(0, 8'h00);
    chk("R10 rst_req after lock", rst_req, 1);
    chk("R9 no late irq", irq_pulse, 0);
    cmp_low = 1'b0; step(3);
  endtask

  task automatic t_reset_src();
    logic [7:0] v;
    wr(1, 8'h00);
    wr(0, 8'h80); wr(1, 8'h09); wr(0, 8'h80);
    @(negedge clk); rst_from_lvd = 1'b1; rst_n = 1'b0;
    step(2); rst_n = 1'b1; rst_from_lvd = 1'b0; step(1);
    rd(0, v); chk("R3 detector reset keeps unlock", v, 8'h82);
    rd(1, v); chk("R3 level reset to init", v, 8'h00);
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
    rd(0, v); chk("R3 other reset clears", v, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_mode_lock();
    t_unlock_settle();
    t_flag_irq();
    t_ir_mode();
    t_masked();
    t_reset_src();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule